// File: doc/BRIEF.md
# AUX Receive Timeout Timer

This block turns a requested receive timeout, given in microseconds, into a compact two-field code made of a length and a range multiplier. It then uses that code to time a receive window. Software or a sequencer loads a request on `cfg_load`. The block stores the encoded pair and shows it on `tmo_len` and `tmo_mul`, so that another unit can program the same pair into a receiver.

The pair selects a time unit of 8, 16, 32 or 64 µs. The code picks the finest unit that can still reach the request, and the length is rounded up so that the coded window is never shorter than the request. When the request exceeds what the coarsest unit can hold, the length clips to its field maximum.

The timer starts when `arm` is pulsed. It then counts 1 µs ticks from `tick_1us`, and when the window runs out it raises `timeout_pulse` for one cycle. A `reply_seen` that arrives first cancels the window. Arming again restarts the count from the full window.

Top module: `aux_rx_timeout`

## Requirements
- R1: After reset, `tmo_len` and `tmo_mul` are 0 and `timeout_pulse` is 0.
- R2: On a clock edge with `cfg_load` high, the multiplier code is chosen from `cfg_us`: code 0 for at most 1016, code 1 for at most 2032, code 2 for at most 4064, and code 3 above 4064. The unit is 8 << code µs, and the new pair is visible from the cycle after that edge.
- R3: The loaded length is `cfg_us` divided by the unit, rounded up whenever the remainder is non-zero. A request of 0 gives length 0.
- R4: The length saturates at 127, which is the largest value of its 7-bit field, for any request above 8128.
- R5: While `cfg_load` is low, `tmo_len` and `tmo_mul` hold their values whatever `cfg_us` does.
- R6: After arming with a pair (L, M) where L is non-zero, `timeout_pulse` goes high for exactly one cycle. That cycle follows the clock edge that samples the L × (8 << M)-th `tick_1us` counted after the arming edge. The timer then goes idle.
- R7: When the armed length is 0, the timer expires on the first tick after the arming edge.
- R8: A `reply_seen` sampled while the timer is running cancels it. This holds even in the cycle of the final tick: no `timeout_pulse` follows until the timer is armed again.
- R9: `arm` loads the currently held pair and restarts the full count, even while the timer is already running. A tick sampled on the arming edge is not counted, and `arm` takes priority over `reply_seen` and over a tick in the same cycle.
- R10: While the timer is idle, ticks never produce `timeout_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Load strobe for the timeout request |
| cfg_us | input | REQ_W | Requested timeout in microseconds |
| tmo_len | output | 7 | Encoded length field |
| tmo_mul | output | 2 | Encoded multiplier code |
| arm | input | 1 | Start or restart the receive window |
| reply_seen | input | 1 | Reply received; cancels the running window |
| tick_1us | input | 1 | One-cycle strobe every microsecond |
| timeout_pulse | output | 1 | One-cycle pulse when the window expires |

## Verification
The bench builds the block with REQ_W = 16, so requests up to 65535 µs can be applied. This covers every multiplier range, each range boundary together with the value one above it, and requests far above the saturation point. The longest window then lasts 8128 ticks. The bench therefore drives ticks on every cycle for long windows and at random density for short ones, so that the exact expiry tick can be checked for each code within the run length.

// File: rtl/aux_tmo_pkg.sv
package aux_tmo_pkg;
  // Width of the encoded length field
  localparam int AUX_LEN_W = 7;
  // Width of the multiplier code
  localparam int AUX_MUL_W = 2;
  // log2 of the finest unit in ticks (8)
  localparam int AUX_UNIT_SHIFT = 3;

  typedef struct packed {
    logic [AUX_MUL_W-1:0] mul;
    logic [AUX_LEN_W-1:0] len;
  } tmo_pair_t;
endpackage

// File: rtl/aux_tmo_encoder.sv
module aux_tmo_encoder
  import aux_tmo_pkg::*;
#(
  parameter int REQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [REQ_W-1:0] req_us,
  output tmo_pair_t        pair_q
);
  localparam int NCODE   = 2 ** AUX_MUL_W;
  localparam int LEN_MAX = 2 ** AUX_LEN_W - 1;

  // The smallest code whose range still reaches the request
  function automatic logic [AUX_MUL_W-1:0] pick_mul(input logic [REQ_W-1:0] us);
    logic [AUX_MUL_W-1:0] m;
    m = AUX_MUL_W'(NCODE - 1);
    for (int k = NCODE - 2; k >= 0; k--) begin
      if (32'(us) <= (32'(LEN_MAX) << (AUX_UNIT_SHIFT + k)))
        m = AUX_MUL_W'(k);
    end
    return m;
  endfunction

  // Divide by a power-of-two unit by shifting, round up with the OR of the
  // dropped bits, then clip to the field maximum
  function automatic logic [AUX_LEN_W-1:0] fit_len(input logic [REQ_W-1:0] us,
                                                   input logic [AUX_MUL_W-1:0] m);
    logic [31:0] wide;
    logic [31:0] quo;
    logic        rem;
    int          sh;
    sh   = AUX_UNIT_SHIFT + int'(m);
    wide = 32'(us);
    quo  = wide >> sh;
    rem  = |(wide & ((32'd1 << sh) - 32'd1));
    quo  = quo + 32'(rem);
    if (quo > 32'(LEN_MAX)) return AUX_LEN_W'(LEN_MAX);
    return quo[AUX_LEN_W-1:0];
  endfunction

  logic [AUX_MUL_W-1:0] next_mul;
  logic [AUX_LEN_W-1:0] next_len;

  always_comb begin
    next_mul = pick_mul(req_us);
    next_len = fit_len(req_us, next_mul);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pair_q <= '0;
    end else if (load) begin
      pair_q.mul <= next_mul;
      pair_q.len <= next_len;
    end
  end
endmodule

// File: rtl/aux_tmo_counter.sv
module aux_tmo_counter #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] start_val,
  input  logic             abort,
  input  logic             tick,
  output logic             running,
  output logic             expire_ev,
  output logic             fire_q
);
  logic [CNT_W-1:0] remain_q;
  logic             active_q;

  // The last counted tick, or the first tick of a zero-length window
  assign expire_ev = active_q && tick && !start && !abort &&
                     (remain_q <= CNT_W'(1));
  assign running   = active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      remain_q <= '0;
      fire_q   <= 1'b0;
    end else begin
      fire_q <= expire_ev;
      if (start) begin
        active_q <= 1'b1;
        remain_q <= start_val;
      end else if (abort) begin
        active_q <= 1'b0;
      end else if (expire_ev) begin
        active_q <= 1'b0;
      end else if (active_q && tick) begin
        remain_q <= remain_q - CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/aux_rx_timeout.sv
module aux_rx_timeout
  import aux_tmo_pkg::*;
#(
  parameter int REQ_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_load,
  input  logic [REQ_W-1:0]     cfg_us,
  output logic [AUX_LEN_W-1:0] tmo_len,
  output logic [AUX_MUL_W-1:0] tmo_mul,
  input  logic                 arm,
  input  logic                 reply_seen,
  input  logic                 tick_1us,
  output logic                 timeout_pulse
);
  localparam int NCODE = 2 ** AUX_MUL_W;
  localparam int CNT_W = AUX_LEN_W + AUX_UNIT_SHIFT + NCODE - 1;

  tmo_pair_t        pair_w;
  logic [CNT_W-1:0] window_w;
  logic             armed_w;
  logic             expire_w;
  logic             cancel_w;

  aux_tmo_encoder #(.REQ_W(REQ_W)) enc_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (cfg_load),
    .req_us (cfg_us),
    .pair_q (pair_w)
  );

  // Window length in ticks: length scaled by the selected unit
  assign window_w = CNT_W'(pair_w.len) << (AUX_UNIT_SHIFT + int'(pair_w.mul));
  assign cancel_w = reply_seen && !arm;

  aux_tmo_counter #(.CNT_W(CNT_W)) cnt_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (arm),
    .start_val (window_w),
    .abort     (cancel_w),
    .tick      (tick_1us),
    .running   (armed_w),
    .expire_ev (expire_w),
    .fire_q    (timeout_pulse)
  );

  assign tmo_len = pair_w.len;
  assign tmo_mul = pair_w.mul;
endmodule

// File: rtl/aux_rx_timeout_chk.sv
module aux_rx_timeout_chk
  import aux_tmo_pkg::*;
#(
  parameter int REQ_W = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cfg_load,
  input logic [REQ_W-1:0]     cfg_us,
  input logic [AUX_LEN_W-1:0] tmo_len,
  input logic [AUX_MUL_W-1:0] tmo_mul,
  input logic                 arm,
  input logic                 reply_seen,
  input logic                 tick_1us,
  input logic                 timeout_pulse,
  input logic                 armed
);
  localparam int LEN_MAX = 2 ** AUX_LEN_W - 1;
  localparam logic [31:0] LIM0 = 32'(LEN_MAX) << AUX_UNIT_SHIFT;

  // Set one cycle after reset is released, so $past never looks into reset
  logic up_q;
  always_ff @(posedge clk) up_q <= rst_n;

  // R2
  small_range_chk: assert property (@(posedge clk) disable iff (!rst_n || !up_q)
    cfg_load |=> ((tmo_mul == '0) == (32'($past(cfg_us)) <= LIM0)));

  // R3
  covers_request_chk: assert property (@(posedge clk) disable iff (!rst_n || !up_q)
    cfg_load |=> ((32'(tmo_len) << (AUX_UNIT_SHIFT + 32'(tmo_mul))) >= 32'($past(cfg_us)))
                 || (32'(tmo_len) == 32'(LEN_MAX)));

  // R5
  pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n || !up_q)
    !cfg_load |=> ($stable(tmo_len) && $stable(tmo_mul)));

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n || !up_q)
    timeout_pulse |=> !timeout_pulse);

  // R6
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n || !up_q)
    timeout_pulse |-> ($past(armed) && $past(tick_1us) && !$past(arm)));

  // R8
  reply_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n || !up_q)
    (reply_seen && !arm) |=> (!timeout_pulse && !armed));

  // R9
  arm_start_chk: assert property (@(posedge clk) disable iff (!rst_n || !up_q)
    arm |=> (armed && !timeout_pulse));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || !up_q)
    (!armed && !arm) |=> !timeout_pulse);
endmodule

bind aux_rx_timeout aux_rx_timeout_chk #(.REQ_W(REQ_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_load      (cfg_load),
  .cfg_us        (cfg_us),
  .tmo_len       (tmo_len),
  .tmo_mul       (tmo_mul),
  .arm           (arm),
  .reply_seen    (reply_seen),
  .tick_1us      (tick_1us),
  .timeout_pulse (timeout_pulse),
  .armed         (armed_w)
);

// File: tb/aux_rx_timeout_tb_top.sv
`timescale 1ns/1ps
module aux_rx_timeout_tb_top;
  localparam int REQ_W = 16;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             cfg_load = 1'b0;
  logic [REQ_W-1:0] cfg_us = '0;
  logic [6:0]       tmo_len;
  logic [1:0]       tmo_mul;
  logic             arm = 1'b0;
  logic             reply_seen = 1'b0;
  logic             tick_1us = 1'b0;
  logic             timeout_pulse;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2 clk = ~clk;

  aux_rx_timeout #(.REQ_W(REQ_W)) dut_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_load      (cfg_load),
    .cfg_us        (cfg_us),
    .tmo_len       (tmo_len),
    .tmo_mul       (tmo_mul),
    .arm           (arm),
    .reply_seen    (reply_seen),
    .tick_1us      (tick_1us),
    .timeout_pulse (timeout_pulse)
  );

  // Reference: the range is found by comparing against the widest reach of each unit
  function automatic int ref_mul(input int us);
    if (us <= 1016) return 0;
    if (us <= 2032) return 1;
    if (us <= 4064) return 2;
    return 3;
  endfunction

  function automatic int ref_len(input int us);
    int unit;
    int q;
    unit = 8 << ref_mul(us);
    q = (us + unit - 1) / unit;
    return (q > 127) ? 127 : q;
  endfunction

  function automatic int ref_ticks(input int us);
    return ref_len(us) * (8 << ref_mul(us));
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic load_cfg(input int us);
    string tag;
    tag = (ref_len(us) == 127 && us > 8128) ? "R4" : ((us % (8 << ref_mul(us))) != 0 ? "R3" : "R2");
    cfg_us = REQ_W'(us);
    cfg_load = 1'b1;
    cyc();
    cfg_load = 1'b0;
    check({tag, " mul"}, int'(tmo_mul), ref_mul(us));
    check({tag, " len"}, int'(tmo_len), ref_len(us));
  endtask

  // Tick until the n-th tick (n >= 1) and check the pulse lands right after it
  task automatic tick_to_expiry(input int n, input bit dense, input string tag);
    int  cnt;
    bit  hit;
    bit  ok;
    cnt = 0;
    ok  = 1'b1;
    hit = 1'b0;
    while (!hit) begin
      tick_1us = dense ? 1'b1 : 1'($urandom % 2);
      cyc();
      if (tick_1us) cnt++;
      hit = tick_1us && (cnt == n);
      if (timeout_pulse != hit) begin
        ok = 1'b0;
        check({tag, " pulse timing"}, int'(timeout_pulse), int'(hit));
      end
    end
    if (ok) check({tag, " pulse timing"}, 1, 1);
    tick_1us = 1'b1;
    cyc();
    check({tag, " single cycle"}, int'(timeout_pulse), 0);
    tick_1us = 1'b0;
  endtask

  task automatic arm_window(input int us, input bit dense);
    int n;
    n = ref_ticks(us);
    arm = 1'b1;
    tick_1us = 1'($urandom % 2);
    cyc();
    arm = 1'b0;
    check("R9 arm cycle", int'(timeout_pulse), 0);
    tick_to_expiry((n == 0) ? 1 : n, dense, (n == 0) ? "R7" : "R6");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) cyc();
    // R1
    check("R1 len", int'(tmo_len), 0);
    check("R1 mul", int'(tmo_mul), 0);
    check("R1 pulse", int'(timeout_pulse), 0);
    rst_n = 1'b1;
    cyc();

    // R10: idle ticks
    begin
      bit quiet;
      quiet = 1'b1;
      tick_1us = 1'b1;
      for (int i = 0; i < 40; i++) begin
        cyc();
        if (timeout_pulse) quiet = 1'b0;
      end
      tick_1us = 1'b0;
      check("R10 idle ticks", int'(quiet), 1);
    end

    // Directed encodings, including range edges and saturation
    load_cfg(0);     load_cfg(1);    load_cfg(8);    load_cfg(9);
    load_cfg(1016);  load_cfg(1017); load_cfg(2032); load_cfg(2033);
    load_cfg(4064);  load_cfg(4065); load_cfg(8128); load_cfg(8129);
    load_cfg(65535);

    // R5: hold while cfg_load is low
    cfg_us = 16'd300;
    cyc();
    check("R5 len hold", int'(tmo_len), 127);
    check("R5 mul hold", int'(tmo_mul), 3);

    // Random encodings
    for (int i = 0; i < 200; i++) load_cfg(int'($urandom % 65536));

    // Timers: zero length, small, range codes, saturated
    load_cfg(0);     arm_window(0, 1'b0);
    load_cfg(1);     arm_window(1, 1'b1);
    load_cfg(9);     arm_window(9, 1'b0);
    load_cfg(300);   arm_window(300, 1'b1);
    load_cfg(1017);  arm_window(1017, 1'b0);
    load_cfg(4065);  arm_window(4065, 1'b1);
    load_cfg(65535); arm_window(65535, 1'b1);
    for (int i = 0; i < 10; i++) begin
      int us;
      us = int'($urandom % 401);
      load_cfg(us);
      arm_window(us, 1'($urandom % 2));
    end

    // R8: reply on the final tick cancels, and later ticks stay quiet
    load_cfg(20);
    arm = 1'b1; cyc(); arm = 1'b0;
    tick_1us = 1'b1;
    repeat (23) cyc();
    reply_seen = 1'b1;
    cyc();
    reply_seen = 1'b0;
    check("R8 cancel on last tick", int'(timeout_pulse), 0);
    begin
      bit quiet;
      quiet = 1'b1;
      for (int i = 0; i < 60; i++) begin
        cyc();
        if (timeout_pulse) quiet = 1'b0;
      end
      check("R8 stays cancelled", int'(quiet), 1);
    end
    tick_1us = 1'b0;

    // R9: restart mid-window with tick and reply in the same cycle
    arm = 1'b1; cyc(); arm = 1'b0;
    tick_1us = 1'b1;
    repeat (10) cyc();
    arm = 1'b1; reply_seen = 1'b1;
    cyc();
    arm = 1'b0; reply_seen = 1'b0;
    check("R9 restart cycle", int'(timeout_pulse), 0);
    tick_to_expiry(24, 1'b1, "R9");

    // R9: arm uses the pair held at the arming edge; a later load does not alter it
    load_cfg(16);
    arm = 1'b1; cfg_us = 16'd800; cfg_load = 1'b1;
    cyc();
    arm = 1'b0; cfg_load = 1'b0;
    tick_to_expiry(16, 1'b1, "R9");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule